// File: doc/BRIEF.md
# Unsigned Adder-Subtractor with Sign-Magnitude Difference

This combinational block takes two unsigned operands of parameterised width (8 bits by default) and a mode bit. With the mode bit low it adds the operands and reports the carry out of the top bit. With the mode bit high it forms the difference by inverting every bit of the second operand and injecting a carry of one into the least significant cell, so one ripple chain serves both operations.

A difference below zero is not returned in wrapped form. If the subtraction ends without a carry out of the top cell, the first operand was the smaller one. A selective two's-complement stage then negates the raw difference, a bank of 2-to-1 multiplexers picks that negated value, and a minus flag is raised. The visible result is therefore a magnitude plus a sign. A separate overflow flag reads the uncorrected sum as a two's-complement value and reports when the signed operation did not fit in the width.

There are no states: the block is a datapath of three leaf stages (operand conditioning, carry chain, magnitude correction). Its only mode transitions are the mode bit selecting add (0) or subtract (1) and, in subtract mode, the end borrow selecting corrected or raw output.

Top module: `addsub_mag`

## Requirements
- R1: With sub_mode = 0, result equals (op_a + op_b) modulo 2^W and cb_flag equals the carry out of the most significant bit.
- R2: With sub_mode = 0, neg_flag is always 0 and no magnitude correction is applied.
- R3: With sub_mode = 1 and op_a >= op_b, result equals op_a - op_b, neg_flag = 0 and cb_flag = 0.
- R4: With sub_mode = 1 and op_a < op_b, result equals op_b - op_a, neg_flag = 1 and cb_flag = 1 (cb_flag is the end borrow in subtract mode).
- R5: With sub_mode = 1 and op_a = op_b, result is zero and neg_flag is 0; a negative result never has zero magnitude.
- R6: ovf_flag is 1 exactly when the operation, with both operands read as W-bit two's-complement values (add when sub_mode = 0, op_a - op_b when sub_mode = 1), yields a value outside [-2^(W-1), 2^(W-1)-1].
- R7: ovf_flag depends on the uncorrected sum only; the magnitude correction does not change it (for example 0x7F - 0x80 at W = 8 gives result 0x01, neg_flag 1 and ovf_flag 1).
- R8: The behaviour holds at any width W >= 2; at W = 4, 0100 - 0111 returns result 0011 with neg_flag 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand (minuend in subtract mode) |
| op_b | input | W | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | W | Sum, or magnitude of the difference |
| neg_flag | output | 1 | Difference was negative (subtract mode only) |
| cb_flag | output | 1 | Carry out in add mode, end borrow in subtract mode |
| ovf_flag | output | 1 | Signed two's-complement overflow of the raw operation |

## Verification
The bench walks every operand pair at width 4 in both modes and a long pseudo-random run at width 8, and adds directed vectors at the edges: equal operands, zero minus all-ones, and the signed extremes 0x7F and 0x80. A design that inverted the borrow polarity would return wrapped differences with the wrong sign, and one that negated on equality would show a minus flag with zero magnitude. If overflow were taken from the corrected magnitude instead of the raw sum, the 0x7F - 0x80 and 0x80 - 0x01 vectors would expose it. A missing carry-in on subtraction would make every difference one too small.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } as_mode_e;
endpackage

// File: rtl/as_operand_cond.sv
// Conditionally inverts the second operand for subtraction.
module as_operand_cond #(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  logic         invert,
    output logic [W-1:0] b_out
);
    for (genvar i = 0; i < W; i++) begin : g_inv
        assign b_out[i] = b_in[i] ^ invert;
    end
endmodule

// File: rtl/as_ripple_adder.sv
// Ripple chain of full-adder cells; exposes the carry into and out of the MSB.
module as_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_msb_in,
    output logic         c_out
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic gen_i;
        logic prop_i;
        assign gen_i        = a[i] & b[i];
        assign prop_i       = a[i] ^ b[i];
        assign sum[i]       = prop_i ^ chain[i];
        assign chain[i+1]   = gen_i | (prop_i & chain[i]);
    end

    assign c_msb_in = chain[W-1];
    assign c_out    = chain[W];
endmodule

// File: rtl/as_magnitude_fix.sv
// Selective two's complement followed by a 2-to-1 multiplexer bank.
module as_magnitude_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         fix_en,
    output logic [W-1:0] mag
);
    logic [W-1:0] seen_one;
    logic [W-1:0] negated;

    // Bits up to and including the lowest set bit are copied; all above are flipped.
    assign seen_one[0] = 1'b0;
    for (genvar i = 1; i < W; i++) begin : g_seen
        assign seen_one[i] = seen_one[i-1] | raw[i-1];
    end

    for (genvar i = 0; i < W; i++) begin : g_neg
        assign negated[i] = raw[i] ^ seen_one[i];
        assign mag[i]     = fix_en ? negated[i] : raw[i];
    end

    always_comb begin
        if (fix_en) begin
            AST_NEG_SUMS_ZERO: assert (W'(raw + negated) == '0); // R4
        end
    end
endmodule

// File: rtl/addsub_mag.sv
module addsub_mag #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_mode,
    output logic [W-1:0] result,
    output logic         neg_flag,
    output logic         cb_flag,
    output logic         ovf_flag
);
    import addsub_pkg::*;

    as_mode_e    mode;
    logic [W-1:0] b_eff;
    logic [W-1:0] raw_sum;
    logic         carry_msb_in;
    logic         carry_end;
    logic         correct_en;

    assign mode = as_mode_e'(sub_mode);

    as_operand_cond #(.W(W)) u_cond (
        .b_in   (op_b),
        .invert (mode == MODE_SUB),
        .b_out  (b_eff)
    );

    as_ripple_adder #(.W(W)) u_chain (
        .a        (op_a),
        .b        (b_eff),
        .cin      (mode == MODE_SUB),
        .sum      (raw_sum),
        .c_msb_in (carry_msb_in),
        .c_out    (carry_end)
    );

    // Output selection per mode
    always_comb begin
        unique case (mode)
            MODE_ADD: begin
                correct_en = 1'b0;
                cb_flag    = carry_end;
            end
            MODE_SUB: begin
                correct_en = ~carry_end;
                cb_flag    = ~carry_end;
            end
            default: begin
                correct_en = 1'b0;
                cb_flag    = 1'b0;
            end
        endcase
    end

    as_magnitude_fix #(.W(W)) u_fix (
        .raw    (raw_sum),
        .fix_en (correct_en),
        .mag    (result)
    );

    assign neg_flag = correct_en;
    assign ovf_flag = carry_msb_in ^ carry_end;

    logic [W-1:0] chk_back;
    always_comb begin
        chk_back = neg_flag ? W'(op_a + result) : W'(op_a - result);
        if (mode == MODE_ADD) begin
            AST_ADD_NOT_NEG: assert (!neg_flag); // R2
        end
        if (mode == MODE_SUB) begin
            AST_SUB_RECOVERS_B: assert (chk_back == op_b); // R3
        end
        if (neg_flag) begin
            AST_NEG_NONZERO: assert (result != '0); // R5
        end
    end
endmodule

// File: tb/sim_addsub_mag.sv
module sim_addsub_mag;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // 8-bit instance
    logic [7:0] a8, b8, r8;
    logic       m8, n8, c8, o8;
    addsub_mag #(.W(8)) u0 (
        .op_a(a8), .op_b(b8), .sub_mode(m8),
        .result(r8), .neg_flag(n8), .cb_flag(c8), .ovf_flag(o8)
    );

    // 4-bit instance
    logic [3:0] a4, b4, r4;
    logic       m4, n4, c4, o4;
    addsub_mag #(.W(4)) u1 (
        .op_a(a4), .op_b(b4), .sub_mode(m4),
        .result(r4), .neg_flag(n4), .cb_flag(c4), .ovf_flag(o4)
    );

    // {mode, a, b, result, neg, cb, ovf}
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1},
        {1'b0, 8'hC8, 8'h64, 8'h2C, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'h05, 8'h03, 8'h02, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h04, 8'h07, 8'h03, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h80, 8'h01, 8'h7F, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h7F, 8'h80, 8'h01, 1'b1, 1'b1, 1'b1},
        {1'b1, 8'h5A, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'h00, 8'h01, 8'h01, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent reference model; compares all four outputs.
    task automatic ref_cmp(input int w, input int m, input int a, input int b,
                           input int res, input int neg, input int cb, input int ovf);
        int mask, half, sa, sb, sr, e_res, e_neg, e_cb, e_ovf;
        string rq;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        sa = (a >= half) ? a - (1 << w) : a;
        sb = (b >= half) ? b - (1 << w) : b;
        if (m == 0) begin
            e_res = (a + b) & mask; e_cb = (a + b) >> w; e_neg = 0; sr = sa + sb;
            rq = "R1";
            chk("R2", "neg add", neg, 0);
        end else begin
            if (a >= b) begin e_res = a - b; e_neg = 0; e_cb = 0; rq = (a == b) ? "R5" : "R3"; end
            else        begin e_res = b - a; e_neg = 1; e_cb = 1; rq = "R4"; end
            sr = sa - sb;
        end
        e_ovf = (sr > half - 1 || sr < -half) ? 1 : 0;
        chk(rq, "result", res, e_res);
        chk(rq, "neg", neg, e_neg);
        chk(rq, "cb", cb, e_cb);
        chk("R6", "ovf", ovf, e_ovf);
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        a8 = '0; b8 = '0; m8 = 1'b0;
        a4 = '0; b4 = '0; m4 = 1'b0;
        @(negedge clk);
        // Idle state with zero operands
        chk("R1", "idle result", int'(r8), 0);
        chk("R2", "idle neg", int'(n8), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            {m8, a8, b8} = VEC[i][27:11];
            @(negedge clk);
            chk(VEC[i][27] ? "R3" : "R1", "tbl result", int'(r8), int'(VEC[i][10:3]));
            chk(VEC[i][27] ? "R4" : "R2", "tbl neg", int'(n8), int'(VEC[i][2]));
            chk(VEC[i][27] ? "R4" : "R1", "tbl cb", int'(c8), int'(VEC[i][1]));
            chk("R7", "tbl ovf", int'(o8), int'(VEC[i][0]));
        end

        // Exhaustive width 4
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    m4 = m[0]; a4 = a[3:0]; b4 = b[3:0];
                    @(negedge clk);
                    ref_cmp(4, m, a, b, int'(r4), int'(n4), int'(c4), int'(o4));
                end
            end
        end

        // Directed R8 example at width 4
        @(posedge clk);
        m4 = 1'b1; a4 = 4'b0100; b4 = 4'b0111;
        @(negedge clk);
        chk("R8", "w4 example result", int'(r4), 3);
        chk("R8", "w4 example neg", int'(n4), 1);

        // Pseudo-random width 8
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(posedge clk);
            a8 = lfsr[7:0]; b8 = lfsr[15:8] ^ 8'(k); m8 = lfsr[3] ^ k[0];
            @(negedge clk);
            ref_cmp(8, int'(m8), int'(a8), int'(b8), int'(r8), int'(n8), int'(c8), int'(o8));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule